// File: doc/BRIEF.md
# SPI Master Controller with Byte Queues

This block drives a serial peripheral bus as its master, one byte per frame. Bytes from the host enter a small transmit queue. A shift engine takes them one at a time, clocks them out on MOSI and captures MISO at the same time. Each captured byte goes into a receive queue for the host to collect. Both queues use valid/ready handshakes. On the transmit side the host holds `tx_valid` with a byte, and the block takes it on any cycle where `tx_ready` is high. On the receive side `rx_valid` marks a byte on `rx_data`, and the host pops it by raising `rx_ready` in a cycle where `rx_valid` is high. Popping when nothing is waiting does nothing.

The clock polarity, clock phase, bit order and SCLK divider are plain configuration inputs. Change them only while the block is idle. A frame starts only when there is something to send, so the host cannot receive without transmitting. For long reads the block has a repeat mode: once the transmit queue runs dry, it keeps starting frames on its own. It sends either the previous byte again or an all-ones busy token.

A received byte that finds the receive queue full is lost. The loss sets a sticky overflow flag and fires a one-cycle interrupt pulse.

Top module: `spi_fifo_master`

## Requirements
- R1: The transmit queue holds 4 bytes; `tx_ready` is low exactly while the queue is full and rises again once the shift engine takes a byte from it; a byte is accepted on a clock edge where `tx_valid` and `tx_ready` are both high.
- R2: `tx_idle` is high after reset, drops in the cycle after a byte is accepted into an empty queue with the shift engine at rest, and returns high only when the queue is empty, the last frame has completed and no repeat stream is active.
- R3: The receive queue holds 4 bytes in arrival order; `rx_valid` is high whenever it holds at least one byte; a pop with `rx_valid` low changes nothing and `rx_data` reads 0x00 while the queue is empty.
- R4: A byte completed while the receive queue is full is discarded, sets `rx_ovf` and pulses `ovf_irq` high for one cycle per lost byte; `rx_ovf` stays set until an `ovf_clr` strobe, and a new loss in the same cycle as the strobe wins.
- R5: A frame is 16 SCLK edges, each half period lasting `cfg_div`+1 clock cycles; a single byte written while idle keeps `tx_idle` low for 16×(`cfg_div`+1)+1 cycles; at rest SCLK sits at the `cfg_cpol` level.
- R6: With `cfg_cpha`=0, MISO is sampled on each leading SCLK edge (the transition away from the rest level) and MOSI changes on trailing edges; with `cfg_cpha`=1, MOSI changes on leading edges and MISO is sampled on trailing edges; this holds for both values of `cfg_cpol`.
- R7: With `cfg_lsb_first`=0, bit 7 goes first on MOSI and the first MISO bit lands in bit 7 of the received byte; with `cfg_lsb_first`=1, bit 0 goes first in both directions.
- R8: With repeat mode on (`rpt_en`=1) and `rpt_token`=0, every frame after the transmit queue empties resends the last byte taken from the queue.
- R9: With repeat mode on and `rpt_token`=1, every frame after the transmit queue empties sends 0xFF.
- R10: A `rpt_wr` strobe loads `rpt_en`/`rpt_token` from `rpt_wr_en`/`rpt_wr_token` only in a cycle where the transmit queue is empty and no frame is in progress, and is otherwise ignored; after an accepted load, repeat frames start only once a new byte has been written.
- R11: With repeat mode off and the transmit queue empty, no frame starts: the number of frames equals the number of bytes written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_valid | input | 1 | Host offers a transmit byte |
| tx_data | input | 8 | Transmit byte |
| tx_ready | output | 1 | Transmit queue has room (transmit-free flag) |
| rx_valid | output | 1 | Receive queue holds a byte |
| rx_data | output | 8 | Oldest received byte, 0x00 when empty |
| rx_ready | input | 1 | Host pops the receive queue |
| cfg_cpol | input | 1 | SCLK rest level |
| cfg_cpha | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| cfg_lsb_first | input | 1 | 1: least significant bit first |
| cfg_div | input | 8 | Half SCLK period minus one, in clock cycles |
| rpt_wr | input | 1 | Strobe to load the repeat settings |
| rpt_wr_en | input | 1 | Repeat enable value to load |
| rpt_wr_token | input | 1 | Repeat source to load: 0 last byte, 1 busy token |
| rpt_en | output | 1 | Current repeat enable |
| rpt_token | output | 1 | Current repeat source |
| ovf_clr | input | 1 | Clears the overflow flag |
| tx_idle | output | 1 | Nothing left to send and engine at rest |
| rx_ovf | output | 1 | Sticky receive overflow flag |
| ovf_irq | output | 1 | One-cycle pulse per discarded byte |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The bench uses the default parameters: 8-bit bytes, 4-entry queues and an 8-bit divider. With queues that shallow, a five-byte burst fills the transmit queue and also overruns the receive queue, so full-queue back-pressure and byte loss both show up within a few frames. Divider values from 0 to 7 keep each frame under 300 cycles. That leaves room for many random rounds across all four clock modes and both bit orders. A bus-slave model in the bench counts SCLK edges and captures MOSI on its own. It also serves a known byte pattern on MISO, so both data directions and the frame count are checked against values the bench computes itself.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int SPIM_BYTE_W = 8;

  typedef enum logic {
    SER_IDLE  = 1'b0,
    SER_SHIFT = 1'b1
  } ser_state_e;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] pop_data,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] cnt;
  logic          wr_ok, rd_ok;

  assign full     = (cnt == FULL_CNT);
  assign empty    = (cnt == '0);
  assign wr_ok    = push && !full;
  assign rd_ok    = pop && !empty;
  assign pop_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (wr_ok) wr_ptr <= (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
      if (rd_ok) rd_ptr <= (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
      case ({wr_ok, rd_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R1 / R3: occupancy never exceeds the queue depth
  assert_depth_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL_CNT);

  // R3: a pop on an empty queue leaves occupancy untouched
  assert_empty_pop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push) |=> empty);
endmodule

// File: rtl/spim_serializer.sv
module spim_serializer
  import spim_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              lsb_first,
  input  logic [DIV_W-1:0]  div,
  input  logic              src_valid,
  input  logic [DATA_W-1:0] src_data,
  output logic              src_pop,
  input  logic              rpt_en,
  input  logic              rpt_token,
  input  logic              rpt_restart,
  output logic              at_rest,
  output logic              armed,
  output logic              sink_push,
  output logic [DATA_W-1:0] sink_data,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso
);
  localparam int EDGES = 2 * DATA_W;
  localparam int EW    = $clog2(EDGES);
  localparam logic [EW-1:0] LAST_EDGE = EW'(EDGES - 1);

  ser_state_e        st;
  logic [DIV_W-1:0]  cnt;
  logic [EW-1:0]     k;
  logic              sck_i;
  logic [DATA_W-1:0] sh_tx, sh_rx, last_q, rx_next;
  logic              edge_now, lead, do_sample, do_shift, start_fifo, start_rpt;

  assign edge_now   = (st == SER_SHIFT) && (cnt == '0);
  assign lead       = ~k[0];
  assign do_sample  = edge_now && (cpha ? !lead : lead);
  assign do_shift   = edge_now && (cpha ? (lead && k != '0) : (!lead && k != LAST_EDGE));
  assign rx_next    = lsb_first ? {miso, sh_rx[DATA_W-1:1]} : {sh_rx[DATA_W-2:0], miso};
  assign start_fifo = (st == SER_IDLE) && src_valid;
  assign start_rpt  = (st == SER_IDLE) && !src_valid && rpt_en && armed;

  assign src_pop   = start_fifo;
  assign at_rest   = (st == SER_IDLE);
  assign sink_push = edge_now && (k == LAST_EDGE);
  assign sink_data = do_sample ? rx_next : sh_rx;
  assign sclk      = cpol ^ sck_i;
  assign mosi      = lsb_first ? sh_tx[0] : sh_tx[DATA_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= SER_IDLE;
      cnt    <= '0;
      k      <= '0;
      sck_i  <= 1'b0;
      sh_tx  <= '0;
      sh_rx  <= '0;
      last_q <= '0;
      armed  <= 1'b0;
    end else begin
      if (st == SER_IDLE) begin
        if (start_fifo) begin
          sh_tx  <= src_data;
          last_q <= src_data;
          armed  <= 1'b1;
          st     <= SER_SHIFT;
          cnt    <= div;
          k      <= '0;
        end else if (start_rpt) begin
          sh_tx <= rpt_token ? '1 : last_q;
          st    <= SER_SHIFT;
          cnt   <= div;
          k     <= '0;
        end
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end else begin
        cnt   <= div;
        sck_i <= ~sck_i;
        k     <= k + 1'b1;
        if (do_sample) sh_rx <= rx_next;
        if (do_shift) sh_tx <= lsb_first ? (sh_tx >> 1) : (sh_tx << 1);
        if (k == LAST_EDGE) st <= SER_IDLE;
      end
      if (rpt_restart) armed <= 1'b0;
    end
  end

  // R5: between frames the clock rests at the polarity level
  assert_rest_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SER_IDLE) |-> (sclk == cpol));

  // R5: a frame always completes with a byte delivered before going back to rest
  assert_frame_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sink_push |=> (st == SER_IDLE));
endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
  import spim_pkg::*;
#(
  parameter int DATA_W   = SPIM_BYTE_W,
  parameter int TX_DEPTH = 4,
  parameter int RX_DEPTH = 4,
  parameter int DIV_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_ready,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  input  logic              rx_ready,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic              cfg_lsb_first,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              rpt_wr,
  input  logic              rpt_wr_en,
  input  logic              rpt_wr_token,
  output logic              rpt_en,
  output logic              rpt_token,
  input  logic              ovf_clr,
  output logic              tx_idle,
  output logic              rx_ovf,
  output logic              ovf_irq,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso
);
  logic              tx_full, tx_empty, tx_pop;
  logic [DATA_W-1:0] tx_head;
  logic              rx_full, rx_empty;
  logic [DATA_W-1:0] rx_head;
  logic              ser_rest, ser_armed, ser_push, rpt_accept, rx_drop;
  logic [DATA_W-1:0] ser_byte;

  spim_fifo #(.W(DATA_W), .DEPTH(TX_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n),
    .push(tx_valid), .push_data(tx_data),
    .pop(tx_pop), .pop_data(tx_head),
    .full(tx_full), .empty(tx_empty)
  );

  spim_fifo #(.W(DATA_W), .DEPTH(RX_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n),
    .push(ser_push), .push_data(ser_byte),
    .pop(rx_ready), .pop_data(rx_head),
    .full(rx_full), .empty(rx_empty)
  );

  spim_serializer #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_ser (
    .clk(clk), .rst_n(rst_n),
    .cpol(cfg_cpol), .cpha(cfg_cpha), .lsb_first(cfg_lsb_first), .div(cfg_div),
    .src_valid(!tx_empty), .src_data(tx_head), .src_pop(tx_pop),
    .rpt_en(rpt_en), .rpt_token(rpt_token), .rpt_restart(rpt_accept),
    .at_rest(ser_rest), .armed(ser_armed),
    .sink_push(ser_push), .sink_data(ser_byte),
    .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  assign tx_ready   = !tx_full;
  assign rx_valid   = !rx_empty;
  assign rx_data    = rx_empty ? '0 : rx_head;
  assign tx_idle    = tx_empty && ser_rest && !(rpt_en && ser_armed);
  assign rpt_accept = rpt_wr && tx_empty && ser_rest;
  assign rx_drop    = ser_push && rx_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rpt_en    <= 1'b0;
      rpt_token <= 1'b0;
      rx_ovf    <= 1'b0;
      ovf_irq   <= 1'b0;
    end else begin
      if (rpt_accept) begin
        rpt_en    <= rpt_wr_en;
        rpt_token <= rpt_wr_token;
      end
      ovf_irq <= rx_drop;
      if (rx_drop)      rx_ovf <= 1'b1;
      else if (ovf_clr) rx_ovf <= 1'b0;
    end
  end

  // R4: a byte arriving at a full receive queue leaves the flag set
  assert_drop_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_push && rx_full) |=> (rx_ovf && ovf_irq));

  // R4: the interrupt pulse never appears without the sticky flag
  assert_irq_has_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_irq |-> rx_ovf);

  // R10: repeat settings hold when a write arrives at the wrong time
  assert_rpt_guard_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rpt_wr && !(tx_empty && ser_rest)) |=> ($stable(rpt_en) && $stable(rpt_token)));

  // R2: idle implies room in the transmit queue
  assert_idle_has_room_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_idle |-> tx_ready);

  // R3: an empty receive queue presents zero
  assert_empty_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> (rx_data == '0));
endmodule

// File: tb/spi_fifo_master_tb.sv
module spi_fifo_master_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_valid = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       tx_ready;
  logic       rx_valid;
  logic [7:0] rx_data;
  logic       rx_ready = 1'b0;
  logic       cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_lsb = 1'b0;
  logic [7:0] cfg_div = 8'd0;
  logic       rpt_wr = 1'b0, rpt_wr_en = 1'b0, rpt_wr_token = 1'b0;
  logic       rpt_en, rpt_token;
  logic       ovf_clr = 1'b0;
  logic       tx_idle, rx_ovf, ovf_irq, sclk, mosi, miso;

  int checks = 0;
  int errors = 0;
  int irq_cnt = 0;

  // bus-slave model state
  int         e = 0;
  int         fr = 0;
  logic [7:0] cap [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_fifo_master dut_i (
    .clk(clk), .rst_n(rst_n),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_lsb_first(cfg_lsb), .cfg_div(cfg_div),
    .rpt_wr(rpt_wr), .rpt_wr_en(rpt_wr_en), .rpt_wr_token(rpt_wr_token),
    .rpt_en(rpt_en), .rpt_token(rpt_token),
    .ovf_clr(ovf_clr), .tx_idle(tx_idle), .rx_ovf(rx_ovf), .ovf_irq(ovf_irq),
    .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  function automatic logic [7:0] sbyte(int f);
    return 8'(f * 29 + 7) ^ 8'hC3;
  endfunction

  function automatic logic slv_bit(int f, int ee, logic ph, logic lsb);
    int idx;
    logic [7:0] b;
    b = sbyte(f);
    if (!ph) idx = ee >> 1;
    else idx = (ee == 0) ? 0 : (ee - 1) >> 1;
    return lsb ? b[idx] : b[7 - idx];
  endfunction

  assign miso = slv_bit(fr, e, cfg_cpha, cfg_lsb);

  always @(posedge sclk or negedge sclk) begin
    if (rst_n) begin
      if (cfg_cpha ? (e % 2 == 1) : (e % 2 == 0)) begin
        cap[fr % 64][cfg_lsb ? (e >> 1) : 7 - (e >> 1)] = mosi;
      end
      e = e + 1;
      if (e == 16) begin
        e = 0;
        fr = fr + 1;
      end
    end
  end

  always @(negedge clk) if (ovf_irq) irq_cnt++;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_cfg(input logic pol, input logic ph, input logic lsb, input logic [7:0] dv);
    @(negedge clk);
    cfg_cpol = pol; cfg_cpha = ph; cfg_lsb = lsb; cfg_div = dv;
    repeat (2) @(negedge clk);
    e = 0;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_valid = 1'b1; tx_data = b;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (!tx_idle && n < 20000) begin @(negedge clk); n++; end
    repeat (2) @(negedge clk);
  endtask

  task automatic pop_chk(input logic [7:0] exp, input string tag);
    @(negedge clk);
    chk(rx_valid === 1'b1 && rx_data === exp, tag, rx_data, exp);
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  task automatic drain();
    @(negedge clk);
    while (rx_valid) begin
      rx_ready = 1'b1; @(negedge clk); rx_ready = 1'b0; @(negedge clk);
    end
    ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0;
  endtask

  task automatic set_rpt(input logic en, input logic tok);
    int n = 0;
    @(negedge clk);
    rpt_wr_en = en; rpt_wr_token = tok; rpt_wr = 1'b1;
    @(negedge clk);
    while (!(rpt_en == en && rpt_token == tok) && n < 5000) begin @(negedge clk); n++; end
    rpt_wr = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed;
    logic [7:0] d [4];
    int start, n, cyc, acc;
    logic [7:0] a;
    seed = 32'd2718;
    void'($urandom(seed));

    repeat (3) @(negedge clk);
    // reset state (R2, R3, R4, R5)
    chk(tx_idle === 1'b1 && tx_ready === 1'b1, "R2 reset idle", tx_idle, 1);
    chk(rx_valid === 1'b0 && rx_data === 8'h00, "R3 reset empty", rx_data, 0);
    chk(rx_ovf === 1'b0 && ovf_irq === 1'b0, "R4 reset flags", rx_ovf, 0);
    chk(sclk === 1'b0, "R5 reset sclk", sclk, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R5: timing of a single frame
    set_cfg(1'b0, 1'b0, 1'b0, 8'd2);
    tx_valid = 1'b1; tx_data = 8'h3C;
    @(negedge clk);
    tx_valid = 1'b0;
    chk(tx_idle === 1'b0, "R2 idle drops after write", tx_idle, 0);
    cyc = 0;
    while (!tx_idle && cyc < 1000) begin cyc++; @(negedge clk); end
    chk(cyc == 16 * 3 + 1, "R5 frame length", cyc, 49);
    chk(sclk === cfg_cpol, "R5 rest level", sclk, cfg_cpol);
    drain();

    // random rounds over all modes and orders (R6, R7, R11, R3)
    for (int r = 0; r < 16; r++) begin
      set_cfg(1'($urandom), 1'($urandom), 1'($urandom), 8'($urandom % 4));
      n = 1 + ($urandom % 4);
      start = fr;
      for (int i = 0; i < n; i++) begin
        d[i] = 8'($urandom);
        push(d[i]);
      end
      wait_idle();
      chk(fr - start == n, "R11 frame count", fr - start, n);
      chk(sclk === cfg_cpol, "R5 rest level after frames", sclk, cfg_cpol);
      for (int i = 0; i < n; i++) begin
        chk(cap[(start + i) % 64] === d[i], cfg_lsb ? "R7 lsb-first mosi" : "R6 R7 msb-first mosi",
            cap[(start + i) % 64], d[i]);
      end
      for (int i = 0; i < n; i++) pop_chk(sbyte(start + i), "R6 R7 R3 received byte");
      chk(rx_valid === 1'b0, "R3 empty after pops", rx_valid, 0);
    end

    // full transmit queue, overflow, repeat write ignored while busy (R1, R4, R10, R3)
    set_cfg(1'b1, 1'b1, 1'b0, 8'd7);
    start = fr;
    irq_cnt = 0;
    acc = 0;
    while (tx_ready && acc < 10) begin
      @(negedge clk);
      tx_valid = 1'b1; tx_data = 8'(8'h10 + acc);
      @(negedge clk);
      tx_valid = 1'b0;
      acc++;
    end
    chk(acc == 5, "R1 bytes accepted before full", acc, 5);
    chk(tx_ready === 1'b0, "R1 ready low when full", tx_ready, 0);
    rpt_wr_en = 1'b1; rpt_wr = 1'b1;
    @(negedge clk);
    rpt_wr = 1'b0; rpt_wr_en = 1'b0;
    @(negedge clk);
    chk(rpt_en === 1'b0, "R10 write ignored while busy", rpt_en, 0);
    cyc = 0;
    while (!tx_ready && cyc < 400) begin @(negedge clk); cyc++; end
    chk(tx_ready === 1'b1, "R1 ready returns", tx_ready, 1);
    wait_idle();
    chk(fr - start == 5, "R11 five frames", fr - start, 5);
    for (int i = 0; i < 5; i++)
      chk(cap[(start + i) % 64] === 8'(8'h10 + i), "R1 byte order out", cap[(start + i) % 64], 8'h10 + i);
    chk(rx_ovf === 1'b1, "R4 overflow set", rx_ovf, 1);
    chk(irq_cnt == 1, "R4 one irq pulse", irq_cnt, 1);
    for (int i = 0; i < 4; i++) pop_chk(sbyte(start + i), "R4 kept bytes");
    chk(rx_ovf === 1'b1, "R4 flag sticky", rx_ovf, 1);
    @(negedge clk);
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
    chk(rx_valid === 1'b0 && rx_data === 8'h00, "R3 empty pop no effect", rx_data, 0);
    ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0; @(negedge clk);
    chk(rx_ovf === 1'b0, "R4 cleared by strobe", rx_ovf, 0);

    // repeat with last byte (R10, R8, R2)
    set_cfg(1'b0, 1'b1, 1'b1, 8'd1);
    set_rpt(1'b1, 1'b0);
    chk(rpt_en === 1'b1 && rpt_token === 1'b0, "R10 write accepted when idle", rpt_en, 1);
    start = fr;
    repeat (100) @(negedge clk);
    chk(fr == start && tx_idle === 1'b1, "R10 no stream before new byte", fr - start, 0);
    a = 8'($urandom);
    push(a);
    cyc = 0;
    while (fr - start < 4 && cyc < 2000) begin @(negedge clk); cyc++; end
    chk(tx_idle === 1'b0, "R2 idle low while streaming", tx_idle, 0);
    set_rpt(1'b0, 1'b0);
    wait_idle();
    n = fr - start;
    chk(n >= 4, "R8 stream length", n, 4);
    for (int i = 0; i < n && i < 60; i++)
      chk(cap[(start + i) % 64] === a, "R8 repeated byte", cap[(start + i) % 64], a);
    drain();

    // repeat with busy token (R9)
    set_cfg(1'b1, 1'b0, 1'b0, 8'd0);
    set_rpt(1'b1, 1'b1);
    start = fr;
    a = 8'h5A;
    push(a);
    cyc = 0;
    while (fr - start < 4 && cyc < 2000) begin @(negedge clk); cyc++; end
    set_rpt(1'b0, 1'b0);
    wait_idle();
    n = fr - start;
    chk(n >= 4, "R9 stream length", n, 4);
    chk(cap[start % 64] === a, "R9 first byte", cap[start % 64], a);
    for (int i = 1; i < n && i < 60; i++)
      chk(cap[(start + i) % 64] === 8'hFF, "R9 busy token", cap[(start + i) % 64], 8'hFF);
    drain();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule